// File: doc/BRIEF.md
# Prescaled Dual-Compare Timer Channel

This block is one 16-bit up-counting timer channel. It picks one of two clock-enable inputs, a slow one and a fast one, and passes the chosen tick through a power-of-two prescaler. The counter advances once per prescaled period. Two compare registers are tested against the count. Each comparator has its own match mode, and a matching comparator sets a sticky flag. The flags drive an interrupt request and a non-maskable-interrupt request, each gated by an external mask, and comparator 2 can also drive a system-reset request. When the system-reset request is armed, the channel works as a watchdog: software must keep writing the counter back to zero before the count reaches the compare 2 period.

Software reaches the channel through four 16-bit registers, selected by a byte offset. Offset 0 is compare 1, offset 2 is compare 2, offset 4 is the counter and offset 6 is the setup register. A write takes effect on the clock edge on which `wr_en` is high. A read is combinational. The first write to setup locks the clock-select, prescaler and mode fields until reset.

Top module: `cmp_timer`

## Requirements

- R1: Register selection and reset state.
  - `addr[2:1]` selects the register: 0 is compare 1, 1 is compare 2, 2 is the counter and 3 is setup.
  - After reset, every register reads 0, and `irq`, `nmi`, `sys_rst` and `cmp_out` are all 0.
- R2: Prescaler.
  - Setup bits [3:0] hold an exponent n.
  - While counting is enabled, the counter advances once every 2^n selected ticks.
- R3: Clock select.
  - Setup bit 4 selects the tick source: 1 selects `tick_fast` and 0 selects `tick_slow`.
  - The tick input that is not selected has no effect on the count.
- R4: Counting and counter writes.
  - Setup bit 15 enables counting.
  - The counter wraps from 0xFFFF to 0.
  - A write to the counter loads the written value and restarts the prescaler.
- R5: Match modes.
  - Setup bits [7:6] hold the comparator 1 mode and bits [9:8] hold the comparator 2 mode.
  - The mode encodings are: 0 disabled, 1 equal, 2 greater-or-equal, 3 event.
  - A match is evaluated on each advance tick, using the count held before that tick.
- R6: Event mode.
  - In event mode, the advance tick on which the count equals the compare value loads the counter with 0 instead of incrementing it.
- R7: Match flags.
  - Setup bit 13 is the comparator 1 match flag and bit 14 is the comparator 2 match flag.
  - A flag stays set until software writes 1 to it through setup.
  - A new match in the same cycle as the clearing write keeps the flag set.
- R8: Interrupt outputs.
  - `irq` is high while some flag is set whose `irq_mask` bit is 1, where bit 0 belongs to comparator 1 and bit 1 to comparator 2.
  - `nmi` follows the same rule, using `nmi_mask`.
- R9: System-reset request.
  - `sys_rst` is high while the comparator 2 flag is set and reset is enabled.
  - Writing compare 2 with a nonzero value enables reset. Writing compare 2 with 0 disables it.
- R10: Setup lock.
  - Setup bit 12 reads 1 after the first setup write.
  - From then until reset, writes to bits [9:6], [4] and [3:0] are ignored.
  - Writes to the compare registers and the counter are still accepted.
- R11: Stop enable.
  - While setup bit 11 is 1 and the comparator 2 flag is set, the counter holds its value.
- R12: Output polarity.
  - `cmp_out[i]` is the flag of comparator i+1.
  - When setup bit 5 is 1, both bits of `cmp_out` are inverted.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_slow | input | 1 | Slow clock-enable input |
| tick_fast | input | 1 | Fast clock-enable input |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the register at `addr` |
| irq_mask | input | 2 | Interrupt enables, one per comparator |
| nmi_mask | input | 2 | Non-maskable-interrupt enables, one per comparator |
| irq | output | 1 | Interrupt request |
| nmi | output | 1 | Non-maskable-interrupt request |
| sys_rst | output | 1 | System-reset request from comparator 2 |
| cmp_out | output | 2 | Comparator flags, with polarity set by setup bit 5 |

## Verification

The assertions check these rules on every cycle:
- the counter moves only by holding, stepping by one or returning to zero, unless software writes it;
- a flag never drops without a write that clears it;
- an event-mode match always reloads the counter to zero;
- the locked setup fields never change;
- a halted counter stays frozen;
- `sys_rst` never rises without the comparator 2 flag.

Only the bench scenarios can show the following:
- the exact prescaled rate for each exponent;
- which tick input the channel follows;
- the cycle on which each match mode fires;
- the set-wins behaviour of a greater-or-equal match against a clearing write;
- the watchdog disarming when compare 2 is written with zero.

// File: rtl/cmp_timer.sv
module cmp_timer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_slow,
  input  logic        tick_fast,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic [1:0]  irq_mask,
  input  logic [1:0]  nmi_mask,
  output logic        irq,
  output logic        nmi,
  output logic        sys_rst,
  output logic [1:0]  cmp_out
);
  localparam int PW = 15;

  function automatic logic hit(input logic [1:0] m, input logic [15:0] c, input logic [15:0] v);
    case (m)
      2'd1, 2'd3: hit = (v == c);
      2'd2:       hit = (v >= c);
      default:    hit = 1'b0;
    endcase
  endfunction

  logic [15:0]   c1, c2, cnt;
  logic [PW-1:0] pre;
  logic [3:0]    div;
  logic [1:0]    m1, m2, flg;
  logic          clksel, rev, stop_en, locked, run, rst_en;

  wire wr_c1  = wr_en && addr[2:1] == 2'd0;
  wire wr_c2  = wr_en && addr[2:1] == 2'd1;
  wire wr_cnt = wr_en && addr[2:1] == 2'd2;
  wire wr_su  = wr_en && addr[2:1] == 2'd3;
  wire unused_bits = ^{addr[0], wdata[12], wdata[10]};

  wire [15:0]   pfull = (16'd1 << div) - 16'd1;
  wire [PW-1:0] pmask = pfull[PW-1:0];
  wire tick   = clksel ? tick_fast : tick_slow;
  wire halt   = stop_en & flg[1];
  wire step   = run & tick & ~halt;
  wire adv    = step && (pre == pmask);
  wire h1     = adv & hit(m1, c1, cnt);
  wire h2     = adv & hit(m2, c2, cnt);
  wire reload = (h1 && m1 == 2'd3) || (h2 && m2 == 2'd3);
  wire [1:0] clr = wr_su ? wdata[14:13] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1 <= '0; c2 <= '0; cnt <= '0; pre <= '0;
      div <= '0; m1 <= '0; m2 <= '0; flg <= '0;
      clksel <= 1'b0; rev <= 1'b0; stop_en <= 1'b0;
      locked <= 1'b0; run <= 1'b0; rst_en <= 1'b0;
    end else begin
      if (wr_c1) c1 <= wdata;
      if (wr_c2) begin
        c2     <= wdata;
        rst_en <= |wdata;
      end
      if (wr_cnt) begin
        cnt <= wdata;
        pre <= '0;
      end else if (step) begin
        if (adv) begin
          pre <= '0;
          cnt <= reload ? 16'd0 : cnt + 16'd1;
        end else begin
          pre <= pre + 1'b1;
        end
      end
      if (wr_su) begin
        run     <= wdata[15];
        stop_en <= wdata[11];
        rev     <= wdata[5];
        locked  <= 1'b1;
        if (!locked) begin
          m2     <= wdata[9:8];
          m1     <= wdata[7:6];
          clksel <= wdata[4];
          div    <= wdata[3:0];
        end
      end
      flg <= (flg & ~clr) | {h2, h1};
    end
  end

  always_comb begin
    case (addr[2:1])
      2'd0:    rdata = c1;
      2'd1:    rdata = c2;
      2'd2:    rdata = cnt;
      default: rdata = {run, flg, locked, stop_en, 1'b0, m2, m1, rev, clksel, div};
    endcase
  end

  assign irq     = |(flg & irq_mask);
  assign nmi     = |(flg & nmi_mask);
  assign sys_rst = flg[1] & rst_en;
  assign cmp_out = flg ^ {2{rev}};
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  addr,
  input logic [15:0] wdata,
  input logic [15:0] cnt,
  input logic [15:0] c1,
  input logic [1:0]  m1,
  input logic [1:0]  m2,
  input logic [1:0]  flg,
  input logic [3:0]  div,
  input logic        clksel,
  input logic        locked,
  input logic        stop_en,
  input logic        adv,
  input logic        sys_rst
);
  wire cw = wr_en && addr[2:1] == 2'd2;
  wire fw = wr_en && addr[2:1] == 2'd3;

  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !cw |=> (cnt == $past(cnt) || cnt == $past(cnt) + 16'd1 || cnt == 16'd0));

  a_r6_event_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && m1 == 2'd3 && cnt == c1 && !cw) |=> cnt == 16'd0);

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flg[0] && !(fw && wdata[13])) |=> flg[0]);

  a_r10_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (locked && $stable({m2, m1, clksel, div})));

  a_r11_stop_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_en && flg[1] && !cw) |=> $stable(cnt));

  a_r9_rst_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> flg[1]);
endmodule

bind cmp_timer cmp_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .cnt(cnt), .c1(c1), .m1(m1), .m2(m2), .flg(flg), .div(div),
  .clksel(clksel), .locked(locked), .stop_en(stop_en), .adv(adv),
  .sys_rst(sys_rst)
);

// File: tb/tb_cmp_timer.sv
module tb_cmp_timer;
  logic clk = 1'b0, rst_n = 1'b0, tick_slow = 1'b0, tick_fast = 1'b1, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [1:0] irq_mask = '0, nmi_mask = '0, cmp_out;
  logic irq, nmi, sys_rst;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  cmp_timer dut (.clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_fast(tick_fast),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_mask(irq_mask),
    .nmi_mask(nmi_mask), .irq(irq), .nmi(nmi), .sys_rst(sys_rst), .cmp_out(cmp_out));

  localparam int NV = 5;
  localparam int VEC [NV][3] = '{'{0, 7, 7}, '{1, 9, 4}, '{2, 40, 10}, '{3, 17, 2}, '{4, 48, 3}};

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; irq_mask = '0; nmi_mask = '0;
    tick_fast = 1'b1; tick_slow = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    do_reset();
    for (int i = 0; i < 4; i++) begin
      rd(3'(2 * i), v);
      chk("R1 register reset", v, 16'h0);
    end
    chk("R1 outputs reset", {11'd0, irq, nmi, sys_rst, cmp_out}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      wr(3'd6, 16'h8010 | 16'(VEC[i][0]));
      run(VEC[i][1]);
      rd(3'd4, v);
      chk("R2 prescaled count", v, 16'(VEC[i][2]));
    end

    do_reset();
    wr(3'd6, 16'h8000);
    run(10);
    rd(3'd4, v);
    chk("R3 fast tick ignored", v, 16'd0);
    tick_slow = 1'b1;
    run(5);
    tick_slow = 1'b0;
    rd(3'd4, v);
    chk("R3 slow tick counted", v, 16'd5);

    do_reset();
    irq_mask = 2'b01;
    wr(3'd0, 16'd5);
    wr(3'd6, 16'h8050);
    run(5);
    chk("R5 equal not yet", {15'd0, irq}, 16'd0);
    run(1);
    rd(3'd6, v);
    chk("R5 equal flag", {15'd0, v[13]}, 16'd1);
    chk("R8 irq on flag", {15'd0, irq}, 16'd1);
    irq_mask = 2'b00;
    #1 chk("R8 irq masked", {15'd0, irq}, 16'd0);
    irq_mask = 2'b01;
    wr(3'd4, 16'hFFFE);
    run(2);
    rd(3'd4, v);
    chk("R4 wrap to zero", v, 16'd0);
    rd(3'd6, v);
    chk("R7 flag sticky", {15'd0, v[13]}, 16'd1);
    wr(3'd6, 16'hA000);
    rd(3'd6, v);
    chk("R7 flag cleared", {15'd0, v[13]}, 16'd0);
    chk("R8 irq drops", {15'd0, irq}, 16'd0);
    chk("R10 fields locked", {6'd0, v[9:0]}, 16'h0050);
    chk("R10 written bit", {15'd0, v[12]}, 16'd1);

    do_reset();
    wr(3'd0, 16'd3);
    wr(3'd6, 16'h80D0);
    run(4);
    rd(3'd4, v);
    chk("R6 reload count", v, 16'd0);
    rd(3'd6, v);
    chk("R6 event flag", {15'd0, v[13]}, 16'd1);
    run(3);
    rd(3'd4, v);
    chk("R6 count again", v, 16'd3);
    run(1);
    rd(3'd4, v);
    chk("R6 second reload", v, 16'd0);

    do_reset();
    nmi_mask = 2'b10;
    wr(3'd2, 16'd3);
    wr(3'd6, 16'h8210);
    run(3);
    chk("R5 ge not yet", {15'd0, nmi}, 16'd0);
    run(1);
    chk("R8 nmi on flag2", {15'd0, nmi}, 16'd1);
    chk("R9 reset request", {15'd0, sys_rst}, 16'd1);
    wr(3'd6, 16'hC000);
    rd(3'd6, v);
    chk("R7 set wins over clear", {15'd0, v[14]}, 16'd1);
    wr(3'd6, 16'h4000);
    wr(3'd6, 16'h4000);
    rd(3'd6, v);
    chk("R7 flag2 cleared when stopped", {15'd0, v[14]}, 16'd0);
    chk("R9 no request without flag", {15'd0, sys_rst}, 16'd0);

    do_reset();
    wr(3'd2, 16'd4);
    wr(3'd6, 16'h8310);
    run(4);
    chk("R9 watchdog not expired", {15'd0, sys_rst}, 16'd0);
    run(1);
    chk("R9 watchdog expired", {15'd0, sys_rst}, 16'd1);
    wr(3'd2, 16'd0);
    rd(3'd6, v);
    chk("R9 flag still set", {15'd0, v[14]}, 16'd1);
    chk("R9 zero period disarms", {15'd0, sys_rst}, 16'd0);

    do_reset();
    wr(3'd2, 16'd2);
    wr(3'd6, 16'h8910);
    run(12);
    rd(3'd4, v);
    chk("R11 counter held", v, 16'd3);

    do_reset();
    wr(3'd6, 16'h0020);
    chk("R12 inverted outputs", {14'd0, cmp_out}, 16'h3);
    wr(3'd6, 16'h03FF);
    rd(3'd6, v);
    chk("R10 locked write ignored", {6'd0, v[9:0]}, 16'h0020);
    wr(3'd4, 16'h1234);
    rd(3'd4, v);
    chk("R10 counter write accepted", v, 16'h1234);
    wr(3'd0, 16'hBEEF);
    rd(3'd0, v);
    chk("R10 compare write accepted", v, 16'hBEEF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule